// File: doc/BRIEF.md
# Registered/Latched Bidirectional Bus Transceiver

This block moves an 18-bit word between two ports, called A and B, in both directions at once. Each direction has its own storage stage and its own set of four controls: a drive enable (active low), a pass-through enable, a direction strobe and a strobe gate (active low). Each path can work in one of three ways. It can pass its input straight through. It can hold a stored word. It can load a new word when its direction strobe rises. Each pin is split into an input, an output value and a per-bit drive enable, so the block can sit inside a larger chip without real tristate nets.

The B port behaves as an open-drain line. A 0 pulls the line low and a 1 releases it, so several drivers can share the line. The A port is a full three-state driver. All logic runs on one system clock. The two direction strobes are sampled on that clock, and a rising edge is detected from two consecutive samples. Reset is asynchronous and active high. It fills both stores with ones, so the B side starts out released.

Top module: `ubx_transceiver`

## Requirements
- R1: When a direction's drive enable is high (inactive), every drive-enable bit of its destination port is 0, whatever the other controls are.
- R2: When a direction's pass-through enable is high, that path's output value equals its input in the same cycle, with no clock edge needed.
- R3: With pass-through low and the strobe gate low, a strobe sampled low at one system edge and high at the next loads the input sampled at that second edge. The new value appears from that edge on.
- R4: With pass-through low and the strobe gate high, strobe edges do not change the stored value.
- R5: With pass-through low and the strobe static, the stored value is held. At the first system edge where pass-through is seen low, two cases apply. If the strobe is high, the input sampled at that edge is loaded. If the strobe is low, the word last sampled while pass-through was high is kept.
- R6: The B port is open drain. The `b_out` value is always 0. Bit i of `b_oe` is 1 exactly when the A-to-B path is enabled and bit i of that path's value is 0.
- R7: The A port is three-state. While the B-to-A path is enabled, all bits of `a_oe` are 1 and `a_out` carries the path value, with both levels driven.
- R8: While reset is high, both stores hold all ones. After reset, with pass-through low, B is fully released and A drives all ones.
- R9: The two paths are independent. When both are enabled at once, each port is driven from its own path and no arbitration takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| a_in | input | 18 | Level seen on the A pins |
| a_out | output | 18 | Value driven onto the A pins |
| a_oe | output | 18 | Per-bit drive enable for the A pins |
| b_in | input | 18 | Level seen on the B pins |
| b_out | output | 18 | Value for the B pins (always low, open drain) |
| b_oe | output | 18 | Per-bit pull-down enable for the B pins |
| ab_oe_n | input | 1 | A-to-B drive enable, active low |
| ab_le | input | 1 | A-to-B pass-through enable |
| ab_clk | input | 1 | A-to-B direction strobe |
| ab_ce_n | input | 1 | A-to-B strobe gate, active low |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| ba_le | input | 1 | B-to-A pass-through enable |
| ba_clk | input | 1 | B-to-A direction strobe |
| ba_ce_n | input | 1 | B-to-A strobe gate, active low |

## Verification
The drive-enable and pass-through results (R1, R2, R6, R7, R9) are combinational, so they are due in the same cycle as the input change. A stored result (R3, R5) shows after the first system edge that samples the strobe high, or that samples pass-through low. Inputs change only on the falling system edge, and every comparison is made 2 to 3 ns later, before the next rising edge. Each check therefore sees one settled cycle. A behavioural model updates on each rising edge and is compared with the ports in every cycle. Directed checks then confirm specific values one edge after each strobe or pass-through change.

// File: rtl/ubx_pkg.sv
package ubx_pkg;

  // Why a path's store changes (or not) on a system edge
  typedef enum logic [1:0] {
    UPD_HOLD     = 2'd0,
    UPD_TRACK    = 2'd1,
    UPD_LE_CLOSE = 2'd2,
    UPD_CLOCK    = 2'd3
  } upd_e;

  // Priority: pass-through tracking, then closing capture, then gated strobe
  function automatic upd_e pick_cause(input logic le, input logic le_fall,
                                      input logic strobe_hi, input logic ce_n,
                                      input logic strobe_rise);
    if (le)                    return UPD_TRACK;
    if (le_fall && strobe_hi)  return UPD_LE_CLOSE;
    if (!ce_n && strobe_rise)  return UPD_CLOCK;
    return UPD_HOLD;
  endfunction

endpackage

// File: rtl/ubx_store.sv
module ubx_store
  import ubx_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic         dclk,
  input  logic         ce_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] val,
  output logic [W-1:0] store,
  output logic         clk_rise,
  output logic         le_fall
);

  logic         dclk_q;
  logic         le_q;
  logic [W-1:0] store_q;
  upd_e         cause;

  assign clk_rise = dclk & ~dclk_q;
  assign le_fall  = ~le & le_q;
  assign cause    = pick_cause(le, le_fall, dclk, ce_n, clk_rise);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      dclk_q  <= 1'b0;
      le_q    <= 1'b0;
      store_q <= '1;
    end else begin
      dclk_q <= dclk;
      le_q   <= le;
      if (cause != UPD_HOLD) store_q <= din;
    end
  end

  assign store = store_q;
  assign val   = le ? din : store_q;

endmodule

// File: rtl/ubx_drive.sv
module ubx_drive #(
  parameter int W          = 18,
  parameter bit OPEN_DRAIN = 1'b0
) (
  input  logic         oe_n,
  input  logic [W-1:0] val,
  output logic [W-1:0] dout,
  output logic [W-1:0] doe
);

  logic en;
  assign en = ~oe_n;

  generate
    if (OPEN_DRAIN) begin : g_od
      assign dout = '0;
      assign doe  = en ? ~val : '0;
    end else begin : g_ts
      assign dout = val;
      assign doe  = {W{en}};
    end
  endgenerate

endmodule

// File: rtl/ubx_transceiver.sv
module ubx_transceiver #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_ce_n,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_ce_n
);

  // Internal events brought out for the bound checker
  logic [W-1:0] ab_val, ab_store, ba_val, ba_store;
  logic         ab_clk_rise, ab_le_fall, ba_clk_rise, ba_le_fall;

  ubx_store #(.W(W)) u_ab_store (
    .clk(clk), .rst(rst), .le(ab_le), .dclk(ab_clk), .ce_n(ab_ce_n),
    .din(a_in), .val(ab_val), .store(ab_store),
    .clk_rise(ab_clk_rise), .le_fall(ab_le_fall)
  );

  ubx_store #(.W(W)) u_ba_store (
    .clk(clk), .rst(rst), .le(ba_le), .dclk(ba_clk), .ce_n(ba_ce_n),
    .din(b_in), .val(ba_val), .store(ba_store),
    .clk_rise(ba_clk_rise), .le_fall(ba_le_fall)
  );

  ubx_drive #(.W(W), .OPEN_DRAIN(1'b1)) u_b_drive (
    .oe_n(ab_oe_n), .val(ab_val), .dout(b_out), .doe(b_oe)
  );

  ubx_drive #(.W(W), .OPEN_DRAIN(1'b0)) u_a_drive (
    .oe_n(ba_oe_n), .val(ba_val), .dout(a_out), .doe(a_oe)
  );

endmodule

// File: rtl/ubx_checker.sv
module ubx_checker #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_oe,
  input logic         ab_oe_n,
  input logic         ab_le,
  input logic         ab_ce_n,
  input logic         ba_oe_n,
  input logic         ba_le,
  input logic [W-1:0] ab_store,
  input logic [W-1:0] ba_store,
  input logic         ab_clk_rise,
  input logic         ab_le_fall
);

  AST_B_RELEASED: assert property (@(posedge clk) disable iff (rst)
    ab_oe_n |-> (b_oe == '0)); // R1
  AST_A_HIZ: assert property (@(posedge clk) disable iff (rst)
    ba_oe_n |-> (a_oe == '0)); // R1
  AST_AB_PASS: assert property (@(posedge clk) disable iff (rst)
    (ab_le && !ab_oe_n) |-> (b_oe == ~a_in)); // R2
  AST_BA_PASS: assert property (@(posedge clk) disable iff (rst)
    ba_le |-> (a_out == b_in)); // R2
  AST_AB_CLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && !ab_ce_n && ab_clk_rise) |=> (ab_store == $past(a_in))); // R3
  AST_AB_GATED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && ab_ce_n && !ab_le_fall) |=> $stable(ab_store)); // R4
  AST_A_FULL_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !ba_oe_n |-> (a_oe == '1)); // R7
  AST_RESET_ONES: assert property (@(posedge clk)
    rst |=> ((ab_store == '1) && (ba_store == '1))); // R8

endmodule

bind ubx_transceiver ubx_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .a_out(a_out),
  .a_oe(a_oe), .b_oe(b_oe), .ab_oe_n(ab_oe_n), .ab_le(ab_le),
  .ab_ce_n(ab_ce_n), .ba_oe_n(ba_oe_n), .ba_le(ba_le),
  .ab_store(ab_store), .ba_store(ba_store),
  .ab_clk_rise(ab_clk_rise), .ab_le_fall(ab_le_fall)
);

// File: tb/ubx_transceiver_tb_top.sv
`timescale 1ns/1ps
module ubx_transceiver_tb_top;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic ab_oe_n = 1'b0, ab_le = 1'b0, ab_clk = 1'b0, ab_ce_n = 1'b1;
  logic ba_oe_n = 1'b0, ba_le = 1'b0, ba_clk = 1'b0, ba_ce_n = 1'b1;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  ubx_transceiver #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_clk(ab_clk), .ab_ce_n(ab_ce_n),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk), .ba_ce_n(ba_ce_n)
  );

  task automatic check(input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%05h expected=%05h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: one held word per direction plus last samples
  logic [W-1:0] m_ab = '1, m_ba = '1;
  bit m_ab_sclk = 0, m_ab_sle = 0, m_ba_sclk = 0, m_ba_sle = 0;

  always @(posedge clk or posedge rst) begin
    if (rst) begin
      m_ab = '1; m_ba = '1;
      m_ab_sclk = 0; m_ab_sle = 0; m_ba_sclk = 0; m_ba_sle = 0;
    end else begin
      if (ab_le || (m_ab_sle && ab_clk) || (!ab_ce_n && ab_clk && !m_ab_sclk))
        m_ab = a_in;
      if (ba_le || (m_ba_sle && ba_clk) || (!ba_ce_n && ba_clk && !m_ba_sclk))
        m_ba = b_in;
      m_ab_sclk = ab_clk; m_ab_sle = ab_le;
      m_ba_sclk = ba_clk; m_ba_sle = ba_le;
    end
  end

  function automatic string mode_tag(input bit oe_n, input bit le, input bit ce_n);
    if (oe_n) return "R1";
    if (le)   return "R2";
    if (ce_n) return "R4";
    return "R3";
  endfunction

  // Every-cycle comparison, 2 ns after inputs move on the falling edge
  always @(negedge clk) begin
    #2;
    if (!done) begin
      logic [W-1:0] ev_ab, ev_ba;
      ev_ab = ab_le ? a_in : m_ab;
      ev_ba = ba_le ? b_in : m_ba;
      check(mode_tag(ab_oe_n, ab_le, ab_ce_n), b_oe, ab_oe_n ? '0 : ~ev_ab);
      check("R6", b_out, '0);
      if (ba_oe_n) check("R1", a_oe, '0);
      else begin
        check("R7", a_oe, '1);
        check(mode_tag(ba_oe_n, ba_le, ba_ce_n), a_out, ev_ba);
      end
    end
  end

  task automatic nedge(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    nedge(3);
    #3;
    check("R8 reset B released", b_oe, '0);
    check("R8 reset A ones", a_out, '1);
    nedge(); rst = 1'b0;
    #3 check("R8 after reset", b_oe, '0);

    // R2 pass-through
    nedge(); ab_le = 1; a_in = 18'h2A5C3;
    #3 check("R2", b_oe, ~18'h2A5C3);
    nedge(); a_in = 18'h15A3C;
    #3 check("R2", b_oe, ~18'h15A3C);

    // R5 closing with strobe low keeps last tracked word
    nedge(); ab_le = 0; a_in = 18'h3FF00;
    #3 check("R5 close strobe low", b_oe, ~18'h15A3C);
    nedge();
    #3 check("R5 hold", b_oe, ~18'h15A3C);

    // R3 gated strobe loads
    nedge(); ab_ce_n = 0; a_in = 18'h0F0F0;
    nedge(); ab_clk = 1;
    #3 check("R3 before edge", b_oe, ~18'h15A3C);
    nedge(); ab_clk = 0; a_in = 18'h11111;
    #3 check("R3", b_oe, ~18'h0F0F0);

    // R4 strobe gate high ignores edges
    nedge(); ab_ce_n = 1; a_in = 18'h22222;
    nedge(); ab_clk = 1;
    nedge(); ab_clk = 0;
    #3 check("R4", b_oe, ~18'h0F0F0);

    // R5 closing with strobe high loads the word at the closing edge
    nedge(); ab_clk = 1; ab_le = 1; a_in = 18'h33333;
    nedge(); ab_le = 0; a_in = 18'h04444;
    nedge(); a_in = 18'h05555;
    #3 check("R5 close strobe high", b_oe, ~18'h04444);
    nedge(); ab_clk = 0;

    // R1 drive enables off
    nedge(); ab_oe_n = 1; ab_le = 1; a_in = '0; ba_oe_n = 1;
    #3 check("R1 B", b_oe, '0);
    check("R1 A", a_oe, '0);

    // R6 open drain on B
    nedge(); ab_oe_n = 0; ba_oe_n = 0; a_in = 18'h0000F;
    #3 check("R6 pulls", b_oe, 18'h3FFF0);
    check("R6 value", b_out, '0);

    // R7 full drive on A, then strobed load B-to-A (R3)
    nedge(); ba_le = 1; b_in = 18'h2AAAA;
    #3 check("R7 value", a_out, 18'h2AAAA);
    check("R7 enable", a_oe, '1);
    nedge(); ba_le = 0; ba_ce_n = 0; b_in = 18'h15555;
    nedge(); ba_clk = 1;
    nedge(); ba_clk = 0; b_in = 18'h00000;
    #3 check("R3 B-to-A", a_out, 18'h15555);

    // R9 both directions enabled together
    nedge(); ab_le = 1; a_in = 18'h12345; ba_le = 1; b_in = 18'h3CAFE;
    $display("NOTE: both directions enabled (configuration error in a system)");
    #3 check("R9 B", b_oe, ~18'h12345);
    check("R9 A", a_out, 18'h3CAFE);

    // Mixed stimulus, compared every cycle by the model
    for (int i = 0; i < 400; i++) begin
      nedge();
      a_in = W'($urandom); b_in = W'($urandom);
      ab_oe_n = ($urandom % 5) == 0; ba_oe_n = ($urandom % 5) == 0;
      ab_le = ($urandom % 4) == 0;   ba_le = ($urandom % 4) == 0;
      ab_clk = $urandom % 2;         ba_clk = $urandom % 2;
      ab_ce_n = $urandom % 2;        ba_ce_n = $urandom % 2;
    end
    nedge(2);
    #3;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    done = 1'b1;
    n_chk++; n_fail++;
    $display("FAIL watchdog R1..R9 run incomplete actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule